// File: doc/BRIEF.md
# Comma-Aligned Serial-to-Word Deframer with Two Half-Rate Word Clocks

This block sits behind a clock-and-data recovery stage and turns its retimed serial bit stream back into 10-bit words. Every bit that enters is shifted into a sliding window, and the window is checked at each bit position for the positive-disparity comma prefix. When it finds one, the word boundary moves to that offset. The block presents words on a registered output together with two word clocks. Each of these clocks runs at half the word rate, and the two are in antiphase. A new word appears on every edge of the pair, alternating between the two clocks.

When the word boundary moves, neither word clock is ever cut short. The phase that is running is stretched, and the output word holds still until the next legal boundary. A comma word is always presented so that it coincides with a rising edge of `rbc1`. If the phase that would be next is the wrong one, the block stretches and inserts one filler half-period, and the word that follows the comma is dropped. Detection can be switched off. While it is off, the block keeps its current boundary and never raises its sync indication.

The serial input carries one bit on each cycle that has `ser_valid` high. The bit stream cannot be paused upstream, so the block has no ready signal and applies no back-pressure. Cycles with `ser_valid` low move nothing.

Top module: `comma_deser`

## Requirements
- R1: The first received bit of a word lands on `rx_word[0]`. A K28.5 comma (received order 0,0,1,1,1,1,1,0,1,0) is therefore presented as 10'h17C.
- R2: A comma is recognised whenever the seven oldest bits of the 10-bit window read 0,0,1,1,1,1,1 in received order. This works at any bit offset, and a match at a new offset moves the word boundary to end at that bit.
- R3: `rbc0` is always the inverse of `rbc1`. `rx_word` changes only in a cycle where `rbc1` toggles.
- R4: Whenever a word flagged as a comma is presented, `rbc1` is high, so the comma word is launched on a rising edge of `rbc1`.
- R5: No half-period of `rbc1` is shorter than 10 valid bits. For a single isolated comma, no half-period is longer than 19 valid bits.
- R6: `byte_sync` is high while the presented word is a comma detected with `sync_en` high, and the presented word then carries the comma prefix in bits 6..0.
- R7: While `sync_en` is low, commas cause no realignment: every half-period stays exactly 10 bits long and `byte_sync` stays low.
- R8: After a comma is presented, the next word is the first or the second data word that followed the comma in the stream, and the words after that follow in stream order.
- R9: A run of back-to-back commas does not lock the block up. A later isolated comma is presented correctly (R4, R6) and is followed by its data in order (R8).
- R10: A cycle with `ser_valid` low changes none of `rx_word`, `rbc1` or `byte_sync`.
- R11: After reset, `rx_word` is 0, `rbc1` is 0, `rbc0` is 1 and `byte_sync` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_valid | input | 1 | Qualifies `ser_bit` for this cycle |
| ser_bit | input | 1 | Retimed serial data bit |
| sync_en | input | 1 | Enables comma detection and realignment |
| rx_word | output | 10 | Presented word, first received bit in bit 0 |
| rbc1 | output | 1 | Half-rate word clock; comma words launch on its rise |
| rbc0 | output | 1 | Half-rate word clock in antiphase to `rbc1` |
| byte_sync | output | 1 | High while a detected comma is presented |

## Verification
Two events can land in the same cycle. One is the completion of a comma in the window; the other is the word boundary of the current alignment, arriving while the word clocks are in the phase that would put the comma on `rbc0`. When both fall together, the block must choose between realigning, presenting normally and inserting a filler half-period.

The bench provokes every combination by sweeping all ten bit offsets against both parities of the preceding word count. In each run it checks that the comma arrives on `rbc1` with `byte_sync` set, that every half-period stays within 10 to 19 bits, and that the data after the comma keeps stream order. A second collision, between an idle input cycle and a word boundary, is provoked by inserting gaps into the stream and is judged by output stability during the gaps.

// File: rtl/comma_deser_pkg.sv
package comma_deser_pkg;

  // Which of the two half-rate word clocks is currently high.
  typedef enum logic {
    PH_LO = 1'b0,   // rbc0 high
    PH_HI = 1'b1    // rbc1 high, comma words launch here
  } word_phase_e;

  function automatic word_phase_e phase_flip(input word_phase_e p);
    return (p == PH_HI) ? PH_LO : PH_HI;
  endfunction

endpackage

// File: rtl/csd_window.sv
// Sliding serial window: the newest bit enters at the top, so bit 0
// holds the oldest bit, which is the first bit of a word.
module csd_window #(
  parameter int unsigned WORD_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv,
  input  logic              bit_in,
  output logic [WORD_W-1:0] win_next
);

  logic [WORD_W-1:0] win_q;

  assign win_next = {bit_in, win_q[WORD_W-1:1]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   win_q <= '0;
    else if (adv) win_q <= win_next;
  end

endmodule

// File: rtl/csd_mark_match.sv
// Compares the oldest MARK_LEN bits of the window with the comma prefix.
module csd_mark_match #(
  parameter int unsigned           WORD_W   = 10,
  parameter int unsigned           MARK_LEN = 7,
  parameter logic [MARK_LEN-1:0]   MARK_PAT = 7'b1111100
) (
  input  logic [WORD_W-1:0] win_next,
  input  logic              enable,
  output logic              hit
);

  logic [MARK_LEN-1:0] bit_eq;

  for (genvar g = 0; g < MARK_LEN; g++) begin : g_cmp
    assign bit_eq[g] = (win_next[g] == MARK_PAT[g]);
  end

  assign hit = enable & (&bit_eq);

endmodule

// File: rtl/csd_framer.sv
// Bit-position counter. Marks the last bit of each word; a comma seen
// off that bit requests a realignment and restarts the count.
module csd_framer #(
  parameter int unsigned WORD_W = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic adv,
  input  logic hit,
  output logic boundary,
  output logic realign
);

  localparam int unsigned CNT_W = $clog2(WORD_W);
  localparam logic [CNT_W-1:0] LAST_POS = CNT_W'(WORD_W - 1);

  logic [CNT_W-1:0] pos_q;

  assign boundary = (pos_q == LAST_POS);
  assign realign  = hit & ~boundary;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q <= '0;
    end else if (adv) begin
      if (boundary || realign) pos_q <= '0;
      else                     pos_q <= pos_q + 1'b1;
    end
  end

endmodule

// File: rtl/csd_present.sv
// One-word staging register plus the output register and clock phase.
// A staged comma is only launched into PH_HI; if the next launch would
// be PH_LO, a filler half-period is inserted with the output held.
module csd_present #(
  parameter int unsigned WORD_W = 10
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            adv,
  input  logic                            boundary,
  input  logic                            realign,
  input  logic                            hit,
  input  logic [WORD_W-1:0]               win_next,
  output logic [WORD_W-1:0]               out_word,
  output comma_deser_pkg::word_phase_e    phase,
  output logic                            out_mark
);

  import comma_deser_pkg::*;

  logic [WORD_W-1:0] stage_q;
  logic              stage_mark_q;
  logic              need_filler;

  assign need_filler = stage_mark_q && (phase == PH_HI);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q      <= '0;
      stage_mark_q <= 1'b0;
      out_word     <= '0;
      out_mark     <= 1'b0;
      phase        <= PH_LO;
    end else if (adv) begin
      if (realign) begin
        // New boundary ends here; current half-period keeps running.
        stage_q      <= win_next;
        stage_mark_q <= 1'b1;
      end else if (boundary) begin
        if (need_filler) begin
          // Stretch: drop into PH_LO with the word unchanged, keep comma staged.
          phase    <= PH_LO;
          out_mark <= 1'b0;
        end else begin
          out_word     <= stage_q;
          out_mark     <= stage_mark_q;
          phase        <= phase_flip(phase);
          stage_q      <= win_next;
          stage_mark_q <= hit;
        end
      end
    end
  end

endmodule

// File: rtl/comma_deser.sv
module comma_deser #(
  parameter int unsigned         WORD_W   = 10,
  parameter int unsigned         MARK_LEN = 7,
  parameter logic [MARK_LEN-1:0] MARK_PAT = 7'b1111100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_valid,
  input  logic              ser_bit,
  input  logic              sync_en,
  output logic [WORD_W-1:0] rx_word,
  output logic              rbc1,
  output logic              rbc0,
  output logic              byte_sync
);

  import comma_deser_pkg::*;

  logic [WORD_W-1:0] win_next;
  logic              hit;
  logic              boundary;
  logic              realign;
  word_phase_e       phase;

  csd_window #(.WORD_W(WORD_W)) win_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .adv      (ser_valid),
    .bit_in   (ser_bit),
    .win_next (win_next)
  );

  csd_mark_match #(.WORD_W(WORD_W), .MARK_LEN(MARK_LEN), .MARK_PAT(MARK_PAT)) match_i (
    .win_next (win_next),
    .enable   (sync_en),
    .hit      (hit)
  );

  csd_framer #(.WORD_W(WORD_W)) frame_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .adv      (ser_valid),
    .hit      (hit),
    .boundary (boundary),
    .realign  (realign)
  );

  csd_present #(.WORD_W(WORD_W)) pres_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .adv      (ser_valid),
    .boundary (boundary),
    .realign  (realign),
    .hit      (hit),
    .win_next (win_next),
    .out_word (rx_word),
    .phase    (phase),
    .out_mark (byte_sync)
  );

  assign rbc1 = (phase == PH_HI);
  assign rbc0 = (phase == PH_LO);

endmodule

// File: rtl/comma_deser_chk.sv
module comma_deser_chk #(
  parameter int unsigned         WORD_W   = 10,
  parameter int unsigned         MARK_LEN = 7,
  parameter logic [MARK_LEN-1:0] MARK_PAT = 7'b1111100
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ser_valid,
  input logic [WORD_W-1:0] rx_word,
  input logic              rbc1,
  input logic              byte_sync
);

  logic       prev_hi;
  logic [7:0] half_len;

  // Valid bits elapsed in the half-period that just ended.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_hi  <= 1'b0;
      half_len <= '0;
    end else begin
      prev_hi <= rbc1;
      if (rbc1 != prev_hi)                  half_len <= ser_valid ? 8'd1 : 8'd0;
      else if (ser_valid && half_len != 8'hFF) half_len <= half_len + 8'd1;
    end
  end

  a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !ser_valid |=> ($stable(rx_word) && $stable(rbc1) && $stable(byte_sync)));

  a_r4_comma_on_hi: assert property (@(posedge clk) disable iff (!rst_n)
    byte_sync |-> rbc1);

  a_r6_sync_carries_mark: assert property (@(posedge clk) disable iff (!rst_n)
    byte_sync |-> (rx_word[MARK_LEN-1:0] == MARK_PAT));

  a_r3_word_moves_on_toggle: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rx_word) |-> !$stable(rbc1));

  a_r5_no_short_half: assert property (@(posedge clk) disable iff (!rst_n)
    (rbc1 != prev_hi) |-> (half_len >= 8'(WORD_W)));

endmodule

bind comma_deser comma_deser_chk #(
  .WORD_W(WORD_W), .MARK_LEN(MARK_LEN), .MARK_PAT(MARK_PAT)
) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .ser_valid (ser_valid),
  .rx_word   (rx_word),
  .rbc1      (rbc1),
  .byte_sync (byte_sync)
);

// File: tb/comma_deser_tb_top.sv
module comma_deser_tb_top;

  localparam logic [9:0] K285    = 10'h17C;  // 0,0,1,1,1,1,1,0,1,0 LSB first
  localparam logic [9:0] DATA_MK = 10'h2DB;  // zeros at bits 2,5,8: no run of 5 ones

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ser_valid = 1'b0;
  logic       ser_bit = 1'b0;
  logic       sync_en = 1'b1;
  logic [9:0] rx_word;
  logic       rbc1, rbc0, byte_sync;

  always #4 clk = ~clk;

  comma_deser dut_i (
    .clk(clk), .rst_n(rst_n), .ser_valid(ser_valid), .ser_bit(ser_bit),
    .sync_en(sync_en), .rx_word(rx_word), .rbc1(rbc1), .rbc0(rbc0),
    .byte_sync(byte_sync)
  );

  int n_chk = 0;
  int n_fail = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // ---------------- monitor ----------------
  logic [9:0] lw [0:511];
  bit         lp [0:511];
  bit         ls [0:511];
  int  ln = 0;
  bit  mon_on = 0, dur_chk = 0, exact_chk = 0;
  int  d = 0, dur_bad = 0, ap_bad = 0, hold_bad = 0, wchg_bad = 0, sync_seen = 0;
  logic [9:0] pw = '0;
  logic pr = 1'b0, ps = 1'b0;

  always @(posedge clk) begin
    #1;
    if (mon_on) begin
      if (rbc0 == rbc1) ap_bad++;
      if (!ser_valid && (rx_word != pw || rbc1 != pr || byte_sync != ps)) hold_bad++;
      if (rbc1 != pr) begin
        if (dur_chk && (d + 1 < 10 || d + 1 > 19)) dur_bad++;
        if (exact_chk && d + 1 != 10) dur_bad++;
        d = 0;
        if (ln < 512) begin lw[ln] = rx_word; lp[ln] = rbc1; ls[ln] = byte_sync; ln++; end
      end else begin
        d++;
        if (rx_word != pw) wchg_bad++;
      end
      if (byte_sync) sync_seen++;
      pw = rx_word; pr = rbc1; ps = byte_sync;
    end
  end

  // ---------------- stimulus helpers ----------------
  bit gap_mode = 0;
  int bit_no = 0;
  int wid = 1;
  logic [9:0] post [0:5];

  function automatic logic [9:0] spread(input int i);
    logic [9:0] w = '0;
    int j = 0;
    for (int b = 0; b < 10; b++) if (DATA_MK[b]) begin w[b] = i[j]; j++; end
    return w;
  endfunction

  function automatic logic [9:0] next_data();
    logic [9:0] w = spread(wid);
    wid = (wid % 127) + 1;
    return w;
  endfunction

  task automatic send_bit(input logic b);
    @(negedge clk);
    ser_bit = b; ser_valid = 1'b1;
    bit_no++;
    if (gap_mode && (bit_no % 3 == 0)) begin
      @(negedge clk);
      ser_valid = 1'b0; ser_bit = ~b;
    end
  endtask

  task automatic send_word(input logic [9:0] w);
    for (int i = 0; i < 10; i++) send_bit(w[i]);
  endtask

  task automatic send_post();
    for (int i = 0; i < 6; i++) begin post[i] = next_data(); send_word(post[i]); end
  endtask

  // Find a flagged comma in the log and judge it and its successors.
  task automatic analyze(input string tag, input bit use_last);
    int c = -1;
    for (int i = 0; i < ln; i++) if (ls[i] && (use_last || c < 0)) c = i;
    check(c >= 0, {tag, " R6 comma flagged"}, 0, 1);
    if (c >= 0) begin
      check(lw[c] == K285, {tag, " R1 comma value"}, lw[c], K285);
      check(lp[c] == 1'b1, {tag, " R4 comma on rbc1"}, lp[c], 1);
      if (c + 2 < ln) begin
        if (lw[c+1] == post[0])
          check(lw[c+2] == post[1], {tag, " R8 order"}, lw[c+2], post[1]);
        else
          check(lw[c+1] == post[1] && lw[c+2] == post[2], {tag, " R8 order"}, lw[c+1], post[1]);
      end else check(1'b0, {tag, " R8 words after comma"}, ln - c, 3);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL R9 watchdog actual=hang expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    check(rx_word == 10'h000, "R11 rx_word", rx_word, 0);
    check(rbc1 == 1'b0 && rbc0 == 1'b1, "R11 clocks", {rbc1, rbc0}, 1);
    check(byte_sync == 1'b0, "R11 byte_sync", byte_sync, 0);
    pw = rx_word; pr = rbc1; ps = byte_sync;
    mon_on = 1;

    // R2/R4/R5/R8: every bit offset against both prefix parities
    for (int k = 0; k < 10; k++) begin
      for (int par = 0; par < 2; par++) begin
        ln = 0;
        for (int s = 0; s < k; s++) send_bit(1'b0);
        for (int p = 0; p < 2 + par; p++) send_word(next_data());
        send_word(K285);
        send_post();
        dur_chk = 1;
        analyze($sformatf("R2 off=%0d par=%0d", k, par), 1'b0);
      end
    end
    check(dur_bad == 0, "R5 half-period length 10..19", dur_bad, 0);

    // R9: back-to-back commas, then an isolated one
    dur_chk = 0;
    ln = 0;
    for (int i = 0; i < 8; i++) send_word(K285);
    for (int i = 0; i < 3; i++) send_word(next_data());
    send_word(K285);
    send_post();
    analyze("R9 after burst", 1'b1);

    // R7: detection disabled, comma at a shifted offset
    for (int i = 0; i < 3; i++) send_word(next_data());
    sync_en = 1'b0;
    dur_bad = 0; sync_seen = 0;
    for (int i = 0; i < 3; i++) send_word(next_data());
    exact_chk = 1;
    for (int s = 0; s < 3; s++) send_bit(1'b0);
    send_word(K285);
    for (int i = 0; i < 6; i++) send_word(next_data());
    for (int s = 0; s < 7; s++) send_bit(1'b0);
    check(sync_seen == 0, "R7 byte_sync stays low", sync_seen, 0);
    check(dur_bad == 0, "R7 half-periods stay 10", dur_bad, 0);
    exact_chk = 0;
    sync_en = 1'b1;

    // R10: idle cycles inside the stream
    gap_mode = 1;
    ln = 0;
    for (int s = 0; s < 4; s++) send_bit(1'b0);
    for (int p = 0; p < 2; p++) send_word(next_data());
    send_word(K285);
    send_post();
    analyze("R10 gaps", 1'b0);
    gap_mode = 0;
    @(negedge clk); ser_valid = 1'b0;
    repeat (4) @(negedge clk);
    check(hold_bad == 0, "R10 outputs hold on idle", hold_bad, 0);
    check(ap_bad == 0, "R3 rbc0 inverse of rbc1", ap_bad, 0);
    check(wchg_bad == 0, "R3 word only changes on toggle", wchg_bad, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule